// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshaked Flush

This block moves data words from a write clock domain to an unrelated read clock domain. Storage depth is a power of two. Each side keeps a binary pointer with one wrap bit above the address bits and a registered Gray copy of it. Only the Gray copy crosses to the other domain, through a chain of flip-flop synchronizers. The read port is first-word-fall-through: while `rd_valid` is high, `rd_data` already shows the oldest entry.

Neither pointer is ever forced to zero. Stale contents are removed by a flush, which only the read side can start. A flush starts on the `flush_req` input or on the read-domain reset, which is treated the same way. A flush runs as a four-phase handshake:
- The read side raises a stall request, which is synchronized into the write domain. There the writer stops accepting data.
- The writer echoes the stall back as an acknowledge through a second synchronizer.
- On that acknowledge, the read side copies the synchronized write pointer into its own pointer, which leaves the FIFO empty.
- The read side then withdraws the request and stays busy until the acknowledge has dropped again.

Top module: `dcfifo_flush`

## Requirements
- R1: From power-up, with no write made, `rd_valid` is 0, `wr_ready` is 1 and `flush_busy` is 0.
- R2: Words accepted on the write port (a `wr_clk` edge with `wr_en` and `wr_ready` high) appear on `rd_data` in acceptance order. Each `rd_clk` edge with `rd_en` and `rd_valid` high removes the head word.
- R3: After 2^ADDR_W words are held, `wr_ready` is 0. A write attempted while `wr_ready` is 0 stores nothing.
- R4: A read attempted while `rd_valid` is 0 removes nothing; later words still come out in order.
- R5: A flush issued while data is held leaves the FIFO empty once `flush_busy` falls (`rd_valid` stays 0 with no new writes). Words written afterwards read back in order.
- R6: `flush_req` high at an `rd_clk` edge while idle makes `flush_busy` 1 after that edge. `rd_valid` is 0 for as long as `flush_busy` is 1.
- R7: During a flush, `wr_ready` goes low once the stall reaches the write domain. The write pointer seen by the read side does not move while the stall is acknowledged. Writes offered while `wr_ready` is low are dropped.
- R8: `flush_req` raised while `flush_busy` is 1 is ignored: the running flush ends and no second flush follows.
- R9: A one-cycle pulse on `rd_rst` starts a flush with the same effect as `flush_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | FIFO can accept a word this cycle (writable) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read-domain reset, starts a flush |
| flush_req | input | 1 | Clear request, starts a flush |
| flush_busy | output | 1 | Flush handshake in progress |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Head word (first-word-fall-through) |
| rd_valid | output | 1 | Head word present (readable) |

## Verification
The hardest state to reach is the window in which the stall has reached the writer but the pointer copy has not yet happened. Writes offered in that window must be dropped and must not leak past the flush.

The bench gets there by issuing a flush while the FIFO holds words. It then watches `wr_ready` at every write-clock falling edge and drives a marker word exactly when `wr_ready` is seen low. After `flush_busy` falls, the FIFO must still read as empty. A second clear request is also injected halfway through a flush, to show that it does not start a further flush once the first one completes.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_REQ,
        FL_COPY,
        FL_DROP
    } flush_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES] = '{default: '0};

    always_ff @(posedge clk) stg[0] <= d;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) stg[i] <= stg[i-1];
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int AW = 4
) (
    input  logic        wr_clk,
    input  logic        wr_en,
    input  logic        stall,
    input  logic [AW:0] rgray_s,
    output logic        wr_ready,
    output logic        wr_fire,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray
);
    logic [AW:0] wbin_q  = '0;
    logic [AW:0] wgray_q = '0;
    logic [AW:0] rbin_s;
    logic [AW:0] wbin_nx;
    logic        full;

    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign full     = (wbin_q ^ rbin_s) == {1'b1, {AW{1'b0}}};
    assign wr_ready = !stall && !full;
    assign wr_fire  = wr_en && wr_ready;
    assign wbin_nx  = wbin_q + 1'b1;

    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign wbin  = wbin_q;
    assign wgray = wgray_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        rd_clk,
    input  logic        rd_en,
    input  logic        start,
    input  logic        ack_s,
    input  logic [AW:0] wgray_s,
    output logic        req,
    output logic        busy,
    output logic        rd_valid,
    output logic [AW:0] rbin,
    output logic [AW:0] rgray
);
    flush_state_e state_q = FL_IDLE;
    logic         req_q   = 1'b0;
    logic [AW:0]  rbin_q  = '0;
    logic [AW:0]  rgray_q = '0;
    logic [AW:0]  wbin_s;
    logic [AW:0]  rbin_nx;
    logic         empty;
    logic         pop;

    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    assign empty    = (rbin_q == wbin_s);
    assign busy     = (state_q != FL_IDLE);
    assign rd_valid = !busy && !empty;
    assign pop      = rd_en && rd_valid;
    assign rbin_nx  = rbin_q + 1'b1;

    always_ff @(posedge rd_clk) begin
        case (state_q)
            FL_IDLE: begin
                if (start) begin
                    state_q <= FL_REQ;
                    req_q   <= 1'b1;
                end else if (pop) begin
                    rbin_q  <= rbin_nx;
                    rgray_q <= rbin_nx ^ (rbin_nx >> 1);
                end
            end
            FL_REQ: begin
                if (ack_s) state_q <= FL_COPY;
            end
            FL_COPY: begin
                rbin_q  <= wbin_s;
                rgray_q <= wgray_s;
                req_q   <= 1'b0;
                state_q <= FL_DROP;
            end
            default: begin
                if (!ack_s) state_q <= FL_IDLE;
            end
        endcase
    end

    assign req   = req_q;
    assign rbin  = rbin_q;
    assign rgray = rgray_q;
endmodule

// File: rtl/dcfifo_flush.sv
module dcfifo_flush
    import dcf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int PTR_SYNC = 2,
    parameter int HS_SYNC  = 2
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              flush_req,
    output logic              flush_busy,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Handshake chains never shorter than pointer chains.
    localparam int HS_LEN = max_int(HS_SYNC, PTR_SYNC);

    logic              wr_fire;
    logic [ADDR_W:0]   w_bin, w_gray, w_gray_rd;
    logic [ADDR_W:0]   r_bin, r_gray, r_gray_wr;
    logic              req_rd, stall_wr, ack_rd;

    dcf_wr_side #(.AW(ADDR_W)) u_wr (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .stall   (stall_wr),
        .rgray_s (r_gray_wr),
        .wr_ready(wr_ready),
        .wr_fire (wr_fire),
        .wbin    (w_bin),
        .wgray   (w_gray)
    );

    dcf_rd_side #(.AW(ADDR_W)) u_rd (
        .rd_clk  (rd_clk),
        .rd_en   (rd_en),
        .start   (flush_req | rd_rst),
        .ack_s   (ack_rd),
        .wgray_s (w_gray_rd),
        .req     (req_rd),
        .busy    (flush_busy),
        .rd_valid(rd_valid),
        .rbin    (r_bin),
        .rgray   (r_gray)
    );

    dcf_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wr_clk(wr_clk),
        .we    (wr_fire),
        .waddr (w_bin[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (r_bin[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    dcf_sync #(.W(ADDR_W+1), .STAGES(PTR_SYNC)) u_wptr_sync (
        .clk(rd_clk), .d(w_gray), .q(w_gray_rd)
    );

    dcf_sync #(.W(ADDR_W+1), .STAGES(PTR_SYNC)) u_rptr_sync (
        .clk(wr_clk), .d(r_gray), .q(r_gray_wr)
    );

    dcf_sync #(.W(1), .STAGES(HS_LEN)) u_req_sync (
        .clk(wr_clk), .d(req_rd), .q(stall_wr)
    );

    dcf_sync #(.W(1), .STAGES(HS_LEN)) u_ack_sync (
        .clk(rd_clk), .d(stall_wr), .q(ack_rd)
    );
endmodule

// File: rtl/dcfifo_flush_chk.sv
module dcfifo_flush_chk #(
    parameter int AW = 4
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        wr_en,
    input logic        wr_ready,
    input logic        rd_en,
    input logic        rd_valid,
    input logic        rd_rst,
    input logic        flush_req,
    input logic        flush_busy,
    input logic        req_rd,
    input logic        ack_rd,
    input logic [AW:0] w_bin,
    input logic [AW:0] r_bin,
    input logic [AW:0] w_gray_rd
);
    logic wr_live = 1'b0;
    logic rd_live = 1'b0;

    always_ff @(posedge wr_clk) wr_live <= 1'b1;
    always_ff @(posedge rd_clk) rd_live <= 1'b1;

    // R3
    blocked_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_live)
        (wr_en && !wr_ready) |=> $stable(w_bin));

    // R2
    write_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_live)
        (wr_en && wr_ready) |=> (w_bin == $past(w_bin) + 1'b1));

    // R4
    empty_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (rd_en && !rd_valid && !flush_busy) |=> $stable(r_bin));

    // R6
    flush_start_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (!flush_busy && (flush_req || rd_rst)) |=> flush_busy);

    // R7
    frozen_wptr_chk: assert property (@(posedge rd_clk) disable iff (!rd_live)
        (ack_rd && req_rd && $past(ack_rd && req_rd)) |-> $stable(w_gray_rd));
endmodule

bind dcfifo_flush dcfifo_flush_chk #(.AW(ADDR_W)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .wr_en     (wr_en),
    .wr_ready  (wr_ready),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_rst    (rd_rst),
    .flush_req (flush_req),
    .flush_busy(flush_busy),
    .req_rd    (req_rd),
    .ack_rd    (ack_rd),
    .w_bin     (w_bin),
    .r_bin     (r_bin),
    .w_gray_rd (w_gray_rd)
);

// File: tb/dcfifo_flush_bench.sv
module dcfifo_flush_bench;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int DEPTH     = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, rd_rst = 1'b0, flush_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, rd_valid, flush_busy;
    logic [DW-1:0] rd_data;

    int            checks = 0;
    int            errors = 0;
    logic [DW-1:0] model [$];

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    dcfifo_flush #(.DATA_W(DW), .ADDR_W(AW)) u_dcfifo_flush (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .flush_req(flush_req),
        .flush_busy(flush_busy), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic push(input logic [DW-1:0] v);
        int n = 0;
        @(negedge wr_clk);
        while (!wr_ready && n < 500) begin @(negedge wr_clk); n++; end
        if (!wr_ready) check(1'b0, "R2 writer stuck", 0, 1);
        wr_en = 1'b1; wr_data = v; model.push_back(v);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_check(input string req);
        int n = 0;
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        while (!rd_valid && n < 500) begin @(negedge rd_clk); n++; end
        exp = (model.size() > 0) ? model.pop_front() : '0;
        check(rd_valid && rd_data == exp, req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!rd_valid && n < 500) begin @(negedge rd_clk); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (flush_busy && n < 2000) begin @(negedge rd_clk); n++; end
        check(!flush_busy, "R5 flush completes", int'(flush_busy), 0);
    endtask

    task automatic t_reset_state();
        rd_wait(3);
        check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        check(flush_busy == 1'b0, "R1 flush_busy", int'(flush_busy), 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        for (int i = 0; i < 5; i++) pop_check("R2 order");
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 12; i++) push(8'(r * 40 + i * 3 + 1));
            for (int i = 0; i < 12; i++) pop_check("R2 wrap order");
        end
    endtask

    task automatic t_empty_read();
        rd_wait(10);
        @(negedge rd_clk); rd_en = 1'b1;
        rd_wait(3);
        rd_en = 1'b0;
        push(8'hC3);
        pop_check("R4 after empty read");
        rd_wait(10);
        check(rd_valid == 1'b0, "R4 nothing extra", int'(rd_valid), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i));
        @(negedge wr_clk);
        check(wr_ready == 1'b0, "R3 full blocks", int'(wr_ready), 0);
        wr_en = 1'b1; wr_data = 8'hEE;
        for (int i = 0; i < 4; i++) @(negedge wr_clk);
        wr_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) pop_check("R3 full order");
        rd_wait(10);
        check(rd_valid == 1'b0, "R3 blocked write dropped", int'(rd_valid), 0);
    endtask

    task automatic t_flush();
        int  n = 0;
        bit  saw_stall = 1'b0;
        for (int i = 0; i < 6; i++) push(8'h40 + 8'(i));
        @(negedge rd_clk);
        wait_valid();
        check(rd_valid == 1'b1, "R5 data held before flush", int'(rd_valid), 1);
        flush_req = 1'b1;
        @(negedge rd_clk);
        flush_req = 1'b0;
        check(flush_busy == 1'b1, "R6 busy after clear", int'(flush_busy), 1);
        check(rd_valid == 1'b0, "R6 readable masked", int'(rd_valid), 0);
        while (flush_busy && n < 2000) begin
            @(negedge wr_clk);
            n++;
            if (!wr_ready) begin
                saw_stall = 1'b1;
                wr_en = 1'b1; wr_data = 8'h5A;
            end else begin
                wr_en = 1'b0;
            end
            if (flush_busy && rd_valid) check(1'b0, "R6 readable during busy", 1, 0);
        end
        wr_en = 1'b0;
        check(saw_stall, "R7 writer stalled", int'(saw_stall), 1);
        model.delete();
        rd_wait(12);
        check(rd_valid == 1'b0, "R5 empty after flush", int'(rd_valid), 0);
        check(rd_valid == 1'b0, "R7 stalled writes dropped", int'(rd_valid), 0);
        for (int i = 0; i < 3; i++) push(8'h61 + 8'(i));
        for (int i = 0; i < 3; i++) pop_check("R5 order after flush");
    endtask

    task automatic t_clear_while_busy();
        int busy_cycles = 0;
        push(8'h01); push(8'h02);
        @(negedge rd_clk);
        wait_valid();
        flush_req = 1'b1;
        @(negedge rd_clk);
        flush_req = 1'b0;
        rd_wait(2);
        check(flush_busy == 1'b1, "R8 busy mid flush", int'(flush_busy), 1);
        flush_req = 1'b1;
        @(negedge rd_clk);
        flush_req = 1'b0;
        wait_idle();
        model.delete();
        for (int i = 0; i < 30; i++) begin
            @(negedge rd_clk);
            if (flush_busy) busy_cycles++;
        end
        check(busy_cycles == 0, "R8 no second flush", busy_cycles, 0);
        push(8'h77);
        pop_check("R8 data after ignored clear");
    endtask

    task automatic t_rd_reset();
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
        @(negedge rd_clk);
        wait_valid();
        rd_rst = 1'b1;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        check(flush_busy == 1'b1, "R9 reset starts flush", int'(flush_busy), 1);
        wait_idle();
        model.delete();
        rd_wait(12);
        check(rd_valid == 1'b0, "R9 empty after reset flush", int'(rd_valid), 0);
        push(8'h3C);
        pop_check("R9 data after reset flush");
    endtask

    initial begin
        #(WR_PERIOD * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        t_reset_state();
        t_order();
        t_empty_read();
        t_full();
        t_flush();
        t_clear_while_busy();
        t_rd_reset();
        summary();
    end
endmodule